// File: doc/BRIEF.md
# Multichannel Serial PCM Output Formatter

This block turns parallel two's-complement PCM samples into serial bit streams. It drives one data line per channel, and all lines share a single bit clock and a single word clock. In every word clock period each channel sends one sample, most significant bit first. The word rate is eight times the base sample rate. Upstream logic, for example a decimation filter, presents one sample per channel on a wide parallel bus. The formatter captures every channel at the same word boundary and then shifts the bits out while the next samples are being prepared.

Two framings are available. The first sends the full 32-bit sample left-justified to the word boundary. The second sends the low 24 bits right-justified in a 32-bit slot, with the eight leading positions filled with copies of the sign bit. A polarity input chooses which word clock level opens a word.

In master mode the block divides the system clock to produce its own bit clock and word clock. In slave mode it oversamples external clocks through synchronizers and follows them. In either mode every serial transition lines up with a falling edge of the bit clock, so a receiver can sample on the rising edge.

Top module: `pcm_serial_fmt`

## Requirements
- R1: Every channel sends its slot most significant bit first. All channels load at the same word boundary and stay bit-aligned on their lines.
- R2: With `fmt_rj_i` = 0, the 32-bit sample of channel c (`samples_i[c*32 +: 32]`) is sent unchanged. Sample bit 31 occupies the first bit period after the boundary.
- R3: With `fmt_rj_i` = 0 in slave mode, if the external bit clock supplies more than 32 periods in one word, every bit from the 33rd on is driven as 0.
- R4: In master mode `bck_o` has a half period of `HALF_DIV` system clock cycles, and every word spans exactly 32 `bck_o` periods. With `wck_inv_i` = 0, `wck_o` is high during bits 0 to 15 and low during bits 16 to 31.
- R5: With `fmt_rj_i` = 1, the slot carries `sample[23:0]` preceded by eight copies of `sample[23]`, which forms a 32-bit sign-extended word. `sample[31:24]` has no effect on the line.
- R6: With `wck_inv_i` = 0 a word opens on a rising word clock transition. With `wck_inv_i` = 1 it opens on a falling transition. In master mode `wck_o` is the inverse of the normal waveform.
- R7: Serial data changes only in response to a falling bit clock edge and is stable across the rising edge. In master mode it changes on the same system clock edge on which `bck_o` falls.
- R8: In slave mode a word boundary is the active word clock transition seen at a falling bit clock edge. That falling edge carries the first slot bit and restarts the bit count. In right-justified mode the slot is also 32 bits long, and any further bits are 0.
- R9: While reset is asserted, `sdata_o` and `bck_o` are 0, and `wck_o` equals `wck_inv_i` in master mode or 0 in slave mode. The data lines stay 0 until the first word boundary.
- R10: The samples and `fmt_rj_i` are captured at the word boundary. Changes during a word affect only the next word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial clocks |
| rst_n | input | 1 | Active-low synchronous reset |
| master_i | input | 1 | 1: generate bit and word clocks; 0: follow external clocks |
| fmt_rj_i | input | 1 | 0: left-justified 32-bit; 1: right-justified 24-bit sign-extended |
| wck_inv_i | input | 1 | Inverts word clock polarity |
| bck_ext_i | input | 1 | External bit clock (slave mode) |
| wck_ext_i | input | 1 | External word clock (slave mode) |
| samples_i | input | NUM_CH*32 | Parallel samples, channel c at bits c*32 +: 32 |
| bck_o | output | 1 | Generated bit clock (0 in slave mode) |
| wck_o | output | 1 | Generated word clock (0 in slave mode) |
| sdata_o | output | NUM_CH | Serial data, one line per channel |

## Verification
In master mode the framing format changes randomly from word to word. This separates a design that captures the format at the boundary from one that follows the input live. It also shows whether the upper byte is ignored and whether sign extension is applied, using samples whose upper byte disagrees with bit 23. Directed samples at the two 24-bit extremes and at the 32-bit most negative value catch a wrong sign source or bit order. In slave mode the bench sends words of 40 external bit periods, which exposes a shifter that recirculates data or fails to zero-fill after bit 32. Both polarities are run, together with idle bit periods that carry no active word clock transition, so that the chosen boundary edge is distinguished from the other one.

// File: rtl/pcm_fmt_pkg.sv
package pcm_fmt_pkg;

    localparam int SLOT_W = 32;
    localparam int RJ_W   = 24;
    localparam int EXT_W  = SLOT_W - RJ_W;
    localparam int CNT_W  = $clog2(SLOT_W) + 1;

    typedef enum logic {
        FMT_LEFT32  = 1'b0,
        FMT_RIGHT24 = 1'b1
    } frame_fmt_e;

    typedef struct packed {
        logic [SLOT_W-1:0] sh;
    } chan_st_t;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             phase;
    } frame_st_t;

    typedef struct packed {
        logic [2:0] bck_sh;
        logic [1:0] wck_sh;
        logic       wck_at_rise;
    } sync_st_t;

    function automatic logic [SLOT_W-1:0] slot_word(input logic [SLOT_W-1:0] s,
                                                    input frame_fmt_e f);
        logic [SLOT_W-1:0] w;
        if (f == FMT_RIGHT24) begin
            w = {{EXT_W{s[RJ_W-1]}}, s[RJ_W-1:0]};
        end else begin
            w = s;
        end
        return w;
    endfunction

endpackage

// File: rtl/pcm_mclk_gen.sv
module pcm_mclk_gen #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable_i,
    output logic bck_o,
    output logic fall_o
);
    localparam int DIV_W = $clog2(HALF_DIV + 1);

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic             bck;
    } mclk_st_t;

    mclk_st_t st_d, st_q;
    logic     tick;

    always_comb begin
        st_d = st_q;
        tick = (st_q.div == DIV_W'(HALF_DIV - 1));
        if (!enable_i) begin
            st_d.div = '0;
            st_d.bck = 1'b0;
        end else if (tick) begin
            st_d.div = '0;
            st_d.bck = ~st_q.bck;
        end else begin
            st_d.div = st_q.div + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bck_o  = st_q.bck;
    assign fall_o = enable_i && tick && st_q.bck;

    // a falling pulse must be followed by a low bit clock
    assert_fall_then_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |=> !bck_o);

endmodule

// File: rtl/pcm_sclk_sync.sv
module pcm_sclk_sync
    import pcm_fmt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable_i,
    input  logic wck_inv_i,
    input  logic bck_ext_i,
    input  logic wck_ext_i,
    output logic fall_o,
    output logic start_o
);
    sync_st_t st_d, st_q;
    logic     bck_s, bck_old, wck_s, rise;

    always_comb begin
        st_d        = st_q;
        bck_s       = st_q.bck_sh[1];
        bck_old     = st_q.bck_sh[2];
        wck_s       = st_q.wck_sh[1];
        rise        = bck_s && !bck_old;
        fall_o      = enable_i && !bck_s && bck_old;
        start_o     = fall_o && (wck_s != st_q.wck_at_rise) && ((wck_s ^ wck_inv_i) == 1'b1);
        st_d.bck_sh = {st_q.bck_sh[1:0], bck_ext_i};
        st_d.wck_sh = {st_q.wck_sh[0], wck_ext_i};
        if (rise) begin
            st_d.wck_at_rise = wck_s;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // one falling event per external edge, never two in a row
    assert_single_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |=> !fall_o);

endmodule

// File: rtl/pcm_frame_ctl.sv
module pcm_frame_ctl
    import pcm_fmt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             master_i,
    input  logic             fall_i,
    input  logic             slave_start_i,
    output logic             load_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic             phase_o
);
    frame_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (master_i) begin
            load_o = fall_i && (st_q.cnt >= CNT_W'(SLOT_W - 1));
        end else begin
            load_o = slave_start_i;
        end
        if (load_o) begin
            st_d.cnt = '0;
        end else if (fall_i && (st_q.cnt < CNT_W'(SLOT_W))) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        if (fall_i) begin
            st_d.phase = (st_d.cnt < CNT_W'(SLOT_W / 2));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cnt   <= CNT_W'(SLOT_W - 1);
            st_q.phase <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o   = st_q.cnt;
    assign phase_o = st_q.phase;

    // checker: falls between successive master word boundaries
    logic [CNT_W-1:0] chk_falls_q;
    logic             chk_seen_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_falls_q <= '0;
            chk_seen_q  <= 1'b0;
        end else if (load_o) begin
            chk_falls_q <= '0;
            chk_seen_q  <= master_i;
        end else begin
            if (!master_i) begin
                chk_seen_q <= 1'b0;
            end
            if (fall_i && (chk_falls_q != '1)) begin
                chk_falls_q <= chk_falls_q + 1'b1;
            end
        end
    end

    assert_master_slot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (master_i && load_o && chk_seen_q) |-> (chk_falls_q == CNT_W'(SLOT_W - 1)));

endmodule

// File: rtl/pcm_chan_shift.sv
module pcm_chan_shift
    import pcm_fmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              fall_i,
    input  frame_fmt_e        fmt_i,
    input  logic [SLOT_W-1:0] sample_i,
    input  logic [CNT_W-1:0]  cnt_i,
    output logic              sdata_o
);
    chan_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.sh = slot_word(sample_i, fmt_i);
        end else if (fall_i) begin
            st_d.sh = {st_q.sh[SLOT_W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sdata_o = st_q.sh[SLOT_W-1];

    assert_zero_after_slot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_i >= CNT_W'(SLOT_W)) |-> !sdata_o);

    assert_change_on_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sdata_o != $past(sdata_o)) |-> $past(fall_i));

    assert_sign_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && fmt_i == FMT_RIGHT24) |=>
        (($countones(st_q.sh[SLOT_W-1 -: EXT_W+1]) == 0) ||
         ($countones(st_q.sh[SLOT_W-1 -: EXT_W+1]) == EXT_W + 1)));

endmodule

// File: rtl/pcm_serial_fmt.sv
module pcm_serial_fmt
    import pcm_fmt_pkg::*;
#(
    parameter int NUM_CH   = 8,
    parameter int HALF_DIV = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     master_i,
    input  logic                     fmt_rj_i,
    input  logic                     wck_inv_i,
    input  logic                     bck_ext_i,
    input  logic                     wck_ext_i,
    input  logic [NUM_CH*SLOT_W-1:0] samples_i,
    output logic                     bck_o,
    output logic                     wck_o,
    output logic [NUM_CH-1:0]        sdata_o
);
    logic             m_bck, m_fall;
    logic             s_fall, s_start;
    logic             fall, load, phase;
    logic [CNT_W-1:0] cnt;

    pcm_mclk_gen #(.HALF_DIV(HALF_DIV)) u_mclk (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable_i (master_i),
        .bck_o    (m_bck),
        .fall_o   (m_fall)
    );

    pcm_sclk_sync u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable_i  (!master_i),
        .wck_inv_i (wck_inv_i),
        .bck_ext_i (bck_ext_i),
        .wck_ext_i (wck_ext_i),
        .fall_o    (s_fall),
        .start_o   (s_start)
    );

    assign fall = master_i ? m_fall : s_fall;

    pcm_frame_ctl u_frame (
        .clk           (clk),
        .rst_n         (rst_n),
        .master_i      (master_i),
        .fall_i        (fall),
        .slave_start_i (s_start),
        .load_o        (load),
        .cnt_o         (cnt),
        .phase_o       (phase)
    );

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
            pcm_chan_shift u_chan (
                .clk      (clk),
                .rst_n    (rst_n),
                .load_i   (load),
                .fall_i   (fall),
                .fmt_i    (frame_fmt_e'(fmt_rj_i)),
                .sample_i (samples_i[c*SLOT_W +: SLOT_W]),
                .cnt_i    (cnt),
                .sdata_o  (sdata_o[c])
            );
        end
    endgenerate

    assign bck_o = master_i ? m_bck : 1'b0;
    assign wck_o = master_i ? (phase ^ wck_inv_i) : 1'b0;

endmodule

// File: tb/sim_pcm_serial_fmt.sv
module sim_pcm_serial_fmt;
    localparam int NCH  = 4;
    localparam int HDIV = 2;
    localparam int HS   = 6;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            master = 1'b1, fmt = 1'b0, inv = 1'b0;
    logic            bck_ext = 1'b1, wck_ext = 1'b0;
    logic [NCH*32-1:0] samples = '0;
    logic            bck_o, wck_o;
    logic [NCH-1:0]  sdata;

    int checks = 0, fails = 0, cyc = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    pcm_serial_fmt #(.NUM_CH(NCH), .HALF_DIV(HDIV)) u0 (
        .clk(clk), .rst_n(rst_n), .master_i(master), .fmt_rj_i(fmt),
        .wck_inv_i(inv), .bck_ext_i(bck_ext), .wck_ext_i(wck_ext),
        .samples_i(samples), .bck_o(bck_o), .wck_o(wck_o), .sdata_o(sdata));

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            checks++; fails++;
            $display("FAIL watchdog R4 actual=%0d cycles expected=end of run", cyc);
            summary();
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_slot(input logic [31:0] s, input logic rj);
        logic [31:0] w;
        if (rj) w = 32'($signed(s[23:0]));
        else    w = s;
        return w;
    endfunction

    int widx = 0;
    task automatic new_samples();
        for (int c = 0; c < NCH; c++) begin
            logic [31:0] v;
            case (widx)
                0: v = (c % 2 == 0) ? 32'h0080_0000 : 32'h8000_0000;
                1: v = (c % 2 == 0) ? 32'hFF7F_FFFF : 32'h007F_FFFF;
                2: v = 32'h5A00_0001 + c;
                default: v = $urandom;
            endcase
            samples[c*32 +: 32] = v;
        end
        widx++;
    endtask

    task automatic do_reset(input logic m, input logic f, input logic i);
        @(negedge clk);
        rst_n = 1'b0; master = m; fmt = f; inv = i;
        bck_ext = 1'b1; wck_ext = i;
        repeat (4) @(negedge clk);
        check(sdata == '0, "R9 reset sdata", 64'(sdata), 64'h0);
        check(bck_o == 1'b0, "R9 reset bck", 64'(bck_o), 64'h0);
        check(wck_o == (m ? i : 1'b0), "R9 reset wck", 64'(wck_o), 64'(m ? i : 1'b0));
        rst_n = 1'b1;
    endtask

    // master mode: monitor generated clocks, change samples and format at each boundary
    task automatic run_master(input int words, input bit rand_fmt);
        logic [31:0] acc [NCH];
        logic [31:0] expw [NCH];
        logic [NCH-1:0] prev_sd;
        logic prev_b, prev_w, w, exp_rj;
        int bits, done_w, last_rise, stable_bad;
        bits = -1; done_w = 0; prev_b = bck_o; prev_w = 1'b0; last_rise = -1;
        stable_bad = 0; prev_sd = sdata; exp_rj = 1'b0;
        for (int k = 0; k < NCH; k++) begin acc[k] = '0; expw[k] = '0; end
        while (done_w < words) begin
            @(negedge clk);
            if (bck_o && !prev_b) begin
                if (last_rise >= 0 && done_w == 1)
                    check(cyc - last_rise == 2 * HDIV, "R4 bck period", 64'(cyc - last_rise), 64'(2 * HDIV));
                last_rise = cyc;
                if (sdata != prev_sd) stable_bad++;
                w = wck_o ^ inv;
                if (!prev_w && w) begin
                    if (bits >= 0) begin
                        check(bits == 32, "R4 bits per word", 64'(bits), 64'd32);
                        check(stable_bad == 0, "R7 stable at rise", 64'(stable_bad), 64'h0);
                        for (int k = 0; k < NCH; k++)
                            check(acc[k] == expw[k], exp_rj ? "R1/R5/R10 master word" : "R1/R2/R10 master word",
                                  64'(acc[k]), 64'(expw[k]));
                        done_w++;
                    end
                    exp_rj = fmt;
                    for (int k = 0; k < NCH; k++) begin
                        expw[k] = exp_slot(samples[k*32 +: 32], fmt);
                        acc[k] = '0;
                    end
                    new_samples();
                    if (rand_fmt) fmt = 1'($urandom);
                    bits = 0; stable_bad = 0;
                end
                if (bits >= 0) begin
                    if (bits == 0 || bits == 16)
                        check(w == (bits == 0), "R4/R6 wck level", 64'(w), 64'(bits == 0));
                    for (int k = 0; k < NCH; k++) acc[k] = {acc[k][30:0], sdata[k]};
                    bits++;
                end
                prev_w = w;
            end
            prev_b = bck_o;
            prev_sd = sdata;
        end
    endtask

    // slave mode: drive one external bit period, return data seen before the rising edge
    task automatic slave_bit(input int b, output logic [NCH-1:0] sd);
        logic [NCH-1:0] hi;
        @(negedge clk);
        bck_ext = 1'b0;
        wck_ext = ((b >= 0 && b < 16) ? 1'b1 : 1'b0) ^ inv;
        repeat (HS) @(negedge clk);
        sd = sdata;
        bck_ext = 1'b1;
        repeat (HS - 1) @(negedge clk);
        hi = sdata;
        check(hi == sd, "R7 stable across rise", 64'(hi), 64'(sd));
    endtask

    task automatic run_slave_idle(input int n);
        logic [NCH-1:0] sd;
        for (int b = 0; b < n; b++) begin
            slave_bit(-1, sd);
            check(sd == '0, "R9 idle before boundary", 64'(sd), 64'h0);
        end
    endtask

    task automatic run_slave_word(input int nbits);
        logic [31:0] acc [NCH];
        logic [31:0] expw [NCH];
        logic [NCH-1:0] sd;
        logic rj;
        rj = fmt;
        for (int k = 0; k < NCH; k++) begin
            expw[k] = exp_slot(samples[k*32 +: 32], fmt);
            acc[k] = '0;
        end
        for (int b = 0; b < nbits; b++) begin
            slave_bit(b, sd);
            if (b == 0) begin
                new_samples();
                fmt = ~fmt;
            end
            if (b < 32) begin
                for (int k = 0; k < NCH; k++) acc[k] = {acc[k][30:0], sd[k]};
            end else begin
                check(sd == '0, rj ? "R8 zero after slot" : "R3 zero after 32nd bit", 64'(sd), 64'h0);
            end
        end
        fmt = rj;
        for (int k = 0; k < NCH; k++)
            check(acc[k] == expw[k], rj ? "R1/R5/R8 slave word" : "R1/R2/R8 slave word",
                  64'(acc[k]), 64'(expw[k]));
    endtask

    initial begin
        void'($urandom(32'd4242));
        new_samples();
        do_reset(1'b1, 1'b0, 1'b0);
        run_master(10, 1'b1);
        do_reset(1'b1, 1'b1, 1'b1);
        run_master(8, 1'b1);
        do_reset(1'b0, 1'b0, 1'b0);
        run_slave_idle(3);
        for (int i = 0; i < 4; i++) begin
            fmt = 1'b0;
            run_slave_word(40);
        end
        do_reset(1'b0, 1'b1, 1'b1);
        run_slave_idle(2);
        for (int i = 0; i < 4; i++) begin
            fmt = 1'b1;
            run_slave_word(32);
        end
        fmt = 1'b0;
        run_slave_word(36);
        done = 1;
        summary();
        $finish;
    end

endmodule